// File: doc/BRIEF.md
# Single-Precision Packing Unit

This unit takes a floating-point value held in an unpacked form and turns it into a 32-bit IEEE-754 single-precision word. The input value is a class code, a sign, a signed unbiased exponent and a normalised mantissa. The mantissa carries the leading integer bit, the 23 fraction bits and two extra low bits (guard and round), and a separate sticky bit comes with it. The unit adds the bias to the exponent. When the biased exponent is too small it shifts the mantissa right into subnormal range. It then rounds under one of four rounding modes, renormalises when the rounding carries out, and resolves overflow either to infinity or to the largest finite value. Along with the packed word it reports three flags: inexact, overflow and underflow.

The unit is the last stage of an arithmetic pipe and holds one register stage between its input and its output. Both sides use a valid/ready stream. An input is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle (`out_ready` high). The result appears on `out_valid` in the cycle after acceptance. While `out_valid` is high and `out_ready` is low, the output word and the flags hold still. Under back-pressure the input side can therefore accept nothing, and the upstream stage must keep its item waiting. The rounding mode and the underflow-trap enable are sampled together with the data.

Top module: `sp_pack_unit`

## Requirements
- R1: An accepted input (in_valid and in_ready high at a rising edge) yields out_valid high on the next cycle. in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid, out_word and the three flags stay unchanged.
- R2: Class code 0 (zero) produces {sign, 31 zero bits} with all flags low.
- R3: Class code 2 (infinity) produces sign in bit 31, exponent field (bits 30:23) 8'hFF and fraction (bits 22:0) zero, with all flags low.
- R4: Class code 3 (NaN) produces the sign, exponent field 8'hFF, and a fraction whose bit 22 is forced to 1 and whose bits 21:0 are mantissa bits 23:2, with all flags low.
- R5: For class code 1 (number), the biased exponent is exponent + 127. When it lies in 1..254, the word is {sign, biased[7:0], fraction}. The result is rounded by in_rmode: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. The mantissa bit 25 is the integer bit, bits 24:2 are the fraction, bit 1 is guard and bit 0 is round.
- R6: out_inexact is high exactly when any of guard, round or sticky is nonzero after any subnormal alignment, and also on overflow.
- R7: A normal result that rounds up to a mantissa of 2.0 gets its exponent field incremented by one and a zero fraction.
- R8: A biased exponent of 255 or more after rounding raises out_overflow and out_inexact. The result is infinity (exponent 8'hFF, fraction 0) in mode 0, in mode 2 with a positive sign and in mode 3 with a negative sign. In every other case it is {sign, 8'hFE, 23'h7FFFFF}.
- R9: A biased exponent of 0 or less shifts the whole mantissa right by (1 - biased) extra places before rounding. The shifted-out bits join the sticky bit, and the exponent field is 0.
- R10: A subnormal that rounds up into bit 23 becomes the smallest normal (exponent field 1, fraction 0) without raising out_underflow.
- R11: A result that stays subnormal, or becomes zero, raises out_underflow when it is inexact or when in_uf_trap is high. Otherwise out_underflow is low.
- R12: A very negative exponent (down to -2048) moves every mantissa bit into sticky. The result is a signed zero, or the smallest subnormal (fraction 1) when the rounding direction points away from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Unit can accept an input this cycle |
| in_cls | input | 2 | Class: 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | 12 | Signed unbiased exponent |
| in_mant | input | 26 | Integer bit, 23 fraction bits, guard, round |
| in_sticky | input | 1 | OR of all bits below round |
| in_rmode | input | 2 | Rounding mode (see R5) |
| in_uf_trap | input | 1 | Underflow-trap enable |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Packed single-precision word |
| out_inexact | output | 1 | Result was rounded |
| out_overflow | output | 1 | Exponent overflow |
| out_underflow | output | 1 | Subnormal-range result under the R11 rule |

## Verification
The assertions assume that a number-class input arrives normalised, with mantissa bit 25 set. They also assume that the class code is one of the four listed and that the consumer eventually raises out_ready. The stimulus sets the integer bit on every number it drives and uses only the four class codes. It drains the output with a stall pattern that never holds out_ready low for long. Exponents are drawn across the whole signed 12-bit range, with extra weight near the overflow and subnormal edges, so that the range assumptions hold while the rare paths are still reached.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } num_class_e;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_TO_ZERO   = 2'd1,
    RND_TO_POS    = 2'd2,
    RND_TO_NEG    = 2'd3
  } rnd_mode_e;

  // Overflow goes to infinity when the rounding direction points away from zero.
  function automatic logic ovf_to_inf(input logic [1:0] mode, input logic sign);
    case (rnd_mode_e'(mode))
      RND_NEAR_EVEN: ovf_to_inf = 1'b1;
      RND_TO_ZERO:   ovf_to_inf = 1'b0;
      RND_TO_POS:    ovf_to_inf = ~sign;
      default:       ovf_to_inf = sign;
    endcase
  endfunction
endpackage

// File: rtl/sp_denorm_shift.sv
module sp_denorm_shift #(
  parameter int MANT_W = 26,
  localparam int SH_W = $clog2(MANT_W + 1)
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [MANT_W-1:0] mant_o,
  output logic              sticky_o
);
  logic [2*MANT_W-1:0] wide;

  always_comb begin
    wide     = {mant_i, {MANT_W{1'b0}}} >> shamt_i;
    mant_o   = wide[2*MANT_W-1:MANT_W];
    sticky_o = sticky_i | (|wide[MANT_W-1:0]);
  end
endmodule

// File: rtl/sp_rounder.sv
module sp_rounder
  import sp_pack_pkg::*;
#(
  parameter int KEEP_W = 24
) (
  input  logic [KEEP_W+1:0] mant_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  output logic [KEEP_W:0]   sum_o,
  output logic              inexact_o
);
  logic guard_b, round_b, lsb_b, bump;

  always_comb begin
    guard_b   = mant_i[1];
    round_b   = mant_i[0];
    lsb_b     = mant_i[2];
    inexact_o = guard_b | round_b | sticky_i;
    case (rnd_mode_e'(mode_i))
      RND_NEAR_EVEN: bump = guard_b & (round_b | sticky_i | lsb_b);
      RND_TO_ZERO:   bump = 1'b0;
      RND_TO_POS:    bump = inexact_o & ~sign_i;
      default:       bump = inexact_o & sign_i;
    endcase
    sum_o = {1'b0, mant_i[KEEP_W+1:2]} + {{KEEP_W{1'b0}}, bump};
  end
endmodule

// File: rtl/sp_pack_unit.sv
module sp_pack_unit
  import sp_pack_pkg::*;
#(
  parameter int FRAC_W    = 23,
  parameter int EXP_W     = 8,
  parameter int IN_EXP_W  = 12,
  localparam int MANT_W   = FRAC_W + 3,
  localparam int WORD_W   = 1 + EXP_W + FRAC_W,
  localparam int BE_W     = IN_EXP_W + 2,
  localparam int SH_W     = $clog2(MANT_W + 1),
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1,
  localparam int EMAX     = (1 << EXP_W) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_cls,
  input  logic                in_sign,
  input  logic [IN_EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]   in_mant,
  input  logic                in_sticky,
  input  logic [1:0]          in_rmode,
  input  logic                in_uf_trap,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_word,
  output logic                out_inexact,
  output logic                out_overflow,
  output logic                out_underflow
);
  logic signed [BE_W-1:0] biased, sh_full, exp_r;
  logic                   is_sub;
  logic [SH_W-1:0]        shamt;
  logic [MANT_W-1:0]      mant_al;
  logic                   sticky_al;
  logic [FRAC_W+1:0]      sum;
  logic                   inexact;
  logic [WORD_W-1:0]      word_n;
  logic                   ix_n, of_n, uf_n;

  always_comb begin
    biased  = $signed({{2{in_exp[IN_EXP_W-1]}}, in_exp}) + BE_W'(BIAS);
    is_sub  = (biased <= 0);
    sh_full = BE_W'(1) - biased;
    if (!is_sub)               shamt = '0;
    else if (sh_full > MANT_W) shamt = SH_W'(MANT_W);
    else                       shamt = sh_full[SH_W-1:0];
  end

  sp_denorm_shift #(.MANT_W(MANT_W)) u_align (
    .mant_i   (in_mant),
    .sticky_i (in_sticky),
    .shamt_i  (shamt),
    .mant_o   (mant_al),
    .sticky_o (sticky_al)
  );

  sp_rounder #(.KEEP_W(FRAC_W + 1)) u_round (
    .mant_i    (mant_al),
    .sticky_i  (sticky_al),
    .sign_i    (in_sign),
    .mode_i    (in_rmode),
    .sum_o     (sum),
    .inexact_o (inexact)
  );

  always_comb begin
    exp_r  = biased + BE_W'(sum[FRAC_W+1]);
    word_n = '0;
    ix_n   = 1'b0;
    of_n   = 1'b0;
    uf_n   = 1'b0;
    case (num_class_e'(in_cls))
      CLS_ZERO: word_n = {in_sign, {(WORD_W-1){1'b0}}};
      CLS_INF:  word_n = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_NAN:  word_n = {in_sign, {EXP_W{1'b1}}, 1'b1, in_mant[MANT_W-3:2]};
      default: begin
        ix_n = inexact;
        if (is_sub) begin
          // a carry into the integer position lands in the exponent LSB
          word_n = {in_sign, {(EXP_W-1){1'b0}}, sum[FRAC_W], sum[FRAC_W-1:0]};
          uf_n   = ~sum[FRAC_W] & (inexact | in_uf_trap);
        end else if (exp_r >= EMAX) begin
          of_n = 1'b1;
          ix_n = 1'b1;
          if (ovf_to_inf(in_rmode, in_sign))
            word_n = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          else
            word_n = {in_sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else begin
          word_n = {in_sign, exp_r[EXP_W-1:0], sum[FRAC_W-1:0]};
        end
      end
    endcase
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_word      <= '0;
      out_inexact   <= 1'b0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word      <= word_n;
        out_inexact   <= ix_n;
        out_overflow  <= of_n;
        out_underflow <= uf_n;
      end
    end
  end
endmodule

// File: rtl/sp_pack_unit_chk.sv
module sp_pack_unit_chk #(
  parameter int FRAC_W = 23,
  parameter int EXP_W  = 8,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_cls,
  input logic              in_sign,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              out_inexact,
  input logic              out_overflow,
  input logic              out_underflow
);
  logic accept;
  assign accept = in_valid & in_ready;

  assert_accept_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_inexact)
                                   && $stable(out_overflow) && $stable(out_underflow)));

  assert_zero_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_cls == 2'd0) |=> (out_word == {$past(in_sign), {(WORD_W-1){1'b0}}}
                                     && !out_inexact && !out_overflow && !out_underflow));

  assert_inf_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_cls == 2'd2) |=> (out_word == {$past(in_sign), {EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  assert_nan_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_cls == 2'd3) |=> (out_word[WORD_W-2:FRAC_W-1] == {(EXP_W+1){1'b1}}
                                     && out_word[WORD_W-1] == $past(in_sign)));

  assert_ovf_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> (out_inexact && out_word[WORD_W-2:FRAC_W+1] == {(EXP_W-1){1'b1}}));

  assert_uf_subrange_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_underflow) |-> (out_word[WORD_W-2:FRAC_W] == '0 && !out_overflow));
endmodule

bind sp_pack_unit sp_pack_unit_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_cls(in_cls), .in_sign(in_sign), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_inexact(out_inexact), .out_overflow(out_overflow),
  .out_underflow(out_underflow)
);

// File: tb/test_sp_pack_unit.sv
`timescale 1ns/1ps
module test_sp_pack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_cls = 2'd0;
  logic        in_sign = 1'b0;
  logic [11:0] in_exp = '0;
  logic [25:0] in_mant = '0;
  logic        in_sticky = 1'b0;
  logic [1:0]  in_rmode = 2'd0;
  logic        in_uf_trap = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_inexact, out_overflow, out_underflow;

  int checks = 0;
  int fails = 0;
  logic [34:0] exp_q[$];
  string       tag_q[$];
  bit          drv_done = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  sp_pack_unit i_sp_pack_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .in_sticky(in_sticky), .in_rmode(in_rmode), .in_uf_trap(in_uf_trap),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_inexact(out_inexact), .out_overflow(out_overflow), .out_underflow(out_underflow)
  );

  // Reference model written from the requirements: {word, inexact, overflow, underflow}
  function automatic logic [34:0] model(input logic [1:0] cls, input logic sg,
      input logic [11:0] ex, input logic [25:0] mn, input logic st,
      input logic [1:0] md, input logic ut);
    int b, e;
    logic [25:0] m;
    logic s, g, r, ix, up, of, uf;
    logic [24:0] k;
    logic [31:0] w;
    of = 1'b0; uf = 1'b0;
    if (cls == 2'd0) return {sg, 31'b0, 3'b000};
    if (cls == 2'd2) return {sg, 8'hFF, 23'b0, 3'b000};
    if (cls == 2'd3) return {sg, 8'hFF, 1'b1, mn[23:2], 3'b000};
    b = int'($signed(ex)) + 127;
    m = mn; s = st;
    if (b <= 0)
      for (int i = 0; i < 1 - b && i < 30; i++) begin s = s | m[0]; m = m >> 1; end
    g = m[1]; r = m[0]; ix = g | r | s;
    case (md)
      2'd0: up = g & (r | s | m[2]);
      2'd1: up = 1'b0;
      2'd2: up = ix & ~sg;
      default: up = ix & sg;
    endcase
    k = {1'b0, m[25:2]} + 25'(up);
    if (b <= 0) begin
      uf = (k[23] == 1'b0) && (ix || ut);
      w = {sg, 7'b0, k[23:0]};
    end else begin
      e = k[24] ? b + 1 : b;
      if (e >= 255) begin
        of = 1'b1; ix = 1'b1;
        if (md == 2'd0 || (md == 2'd2 && !sg) || (md == 2'd3 && sg)) w = {sg, 8'hFF, 23'b0};
        else w = {sg, 8'hFE, 23'h7FFFFF};
      end else w = {sg, 8'(e), k[22:0]};
    end
    return {w, ix, of, uf};
  endfunction

  task automatic send(input string tag, input logic [1:0] cls, input logic sg,
      input int ex, input logic [25:0] mn, input logic st, input logic [1:0] md,
      input logic ut);
    @(negedge clk);
    in_valid = 1'b1; in_cls = cls; in_sign = sg; in_exp = 12'(ex);
    in_mant = mn; in_sticky = st; in_rmode = md; in_uf_trap = ut;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(cls, sg, 12'(ex), mn, st, md, ut));
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor: drives the stall pattern and scores results
  initial begin : monitor
    int cyc = 0;
    logic stalled = 1'b0;
    logic [34:0] held = '0;
    logic [34:0] got, want;
    string tg;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        got = {out_word, out_inexact, out_overflow, out_underflow};
        if (stalled) begin
          checks++;
          if (!out_valid || got != held) begin
            fails++;
            $display("FAIL R1 stall hold: actual %h expected %h", got, held);
          end
        end
        cyc++;
        out_ready = !((cyc % 7) == 3 || (cyc % 7) == 4);
        stalled = out_valid && !out_ready;
        held = got;
        if (out_valid && out_ready) begin
          checks++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R1 unexpected output: actual %h expected none", got);
          end else begin
            want = exp_q.pop_front();
            tg = tag_q.pop_front();
            if (got != want) begin
              fails++;
              $display("FAIL %s: actual %h expected %h", tg, got, want);
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual hung expected drained");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : driver
    logic [25:0] rm;
    int re;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset state: actual %b%b expected 01", out_valid, in_ready);
    end
    rst_n = 1'b1;
    // R2 / R3 / R4 special classes
    send("R2 pos zero", 2'd0, 0, 0, 26'h0, 0, 0, 1);
    send("R2 neg zero", 2'd0, 1, 5, 26'h3FFFFFF, 1, 2, 0);
    send("R3 neg inf", 2'd2, 1, 0, 26'h2ABCDEF, 1, 0, 0);
    send("R4 nan quiet forced", 2'd3, 0, 0, 26'h2155557, 0, 0, 0);
    send("R4 nan neg", 2'd3, 1, 0, 26'h3FFFFFC, 1, 1, 0);
    // R5 / R6 normals and rounding modes
    send("R5 one", 2'd1, 0, 0, 26'h2000000, 0, 0, 0);
    send("R6 exact 1.5", 2'd1, 0, 0, 26'h3000000, 0, 0, 0);
    send("R5 tie even down", 2'd1, 0, 0, 26'h2000002, 0, 0, 0);
    send("R5 tie odd up", 2'd1, 0, 0, 26'h2000006, 0, 0, 0);
    send("R6 sticky only RNE", 2'd1, 1, 3, 26'h2000004, 1, 0, 0);
    send("R5 RZ", 2'd1, 0, -10, 26'h2FFFFFF, 0, 1, 0);
    send("R5 RP pos", 2'd1, 0, -10, 26'h2000001, 0, 2, 0);
    send("R5 RP neg", 2'd1, 1, -10, 26'h2000001, 0, 2, 0);
    send("R5 RM neg", 2'd1, 1, 20, 26'h2000000, 1, 3, 0);
    // R7 carry to 2.0
    send("R7 carry renorm", 2'd1, 0, 0, 26'h3FFFFFF, 0, 0, 0);
    send("R7 carry RP", 2'd1, 0, 126, 26'h3FFFFFC, 1, 2, 0);
    // R8 overflow
    send("R8 ovf RNE inf", 2'd1, 0, 127, 26'h3FFFFFF, 0, 0, 0);
    send("R8 ovf RZ max", 2'd1, 1, 127, 26'h3FFFFFF, 0, 1, 0);
    send("R8 ovf RM pos max", 2'd1, 0, 128, 26'h2000000, 0, 3, 0);
    send("R8 ovf RM neg inf", 2'd1, 1, 128, 26'h2000000, 0, 3, 0);
    send("R8 ovf huge exp", 2'd1, 0, 2000, 26'h2000000, 0, 2, 0);
    // R9 / R10 / R11 subnormals
    send("R9 sub exact", 2'd1, 0, -127, 26'h2000000, 0, 0, 0);
    send("R11 sub exact trap", 2'd1, 0, -127, 26'h2000000, 0, 0, 1);
    send("R9 sub deep", 2'd1, 1, -140, 26'h2345678, 0, 1, 0);
    send("R10 sub carry normal", 2'd1, 0, -127, 26'h3FFFFFF, 0, 0, 0);
    send("R10 sub carry trap", 2'd1, 1, -127, 26'h3FFFFFF, 1, 3, 1);
    send("R11 sub inexact", 2'd1, 0, -130, 26'h2000001, 0, 1, 0);
    // R12 everything into sticky
    send("R12 zero RNE", 2'd1, 0, -2000, 26'h2000000, 0, 0, 0);
    send("R12 min sub RP", 2'd1, 0, -2048, 26'h2000000, 0, 2, 0);
    send("R12 min sub RM neg", 2'd1, 1, -500, 26'h3FFFFFF, 0, 3, 0);
    send("R12 zero RM pos", 2'd1, 0, -500, 26'h3FFFFFF, 0, 3, 0);
    // mixed pseudo-random stimulus
    for (int n = 0; n < 400; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      rm = {1'b1, lfsr[24:0]};
      case (lfsr[27:26])
        2'd0: re = int'(lfsr[7:0]) - 160;
        2'd1: re = int'(lfsr[5:0]) + 100;
        2'd2: re = int'($signed(lfsr[11:0]));
        default: re = int'(lfsr[5:0]) - 32;
      endcase
      send("R5 R6 R9 random", (lfsr[31:29] == 3'd0) ? lfsr[1:0] : 2'd1,
           lfsr[28], re, rm, lfsr[25], lfsr[9:8], lfsr[30]);
    end
    drv_done = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule